// File: doc/BRIEF.md
# Staggered Burst Dimming Generator

This block turns a digital brightness setting into a burst-enable waveform for four lamp channels. All four channels share one dimming period. The period begins at each period-start pulse and is measured in lamp-cycle ticks. A shared dimming signal is high for a fraction of the period, and that fraction comes from an 8-bit brightness code. The mapping can use either slope, and a disable control forces the lamps fully on.

Each channel repeats the shared burst shifted later in the period. The shift is set by the channel's own 8-bit stagger code. Its unit is a step of 1, 2, 4 or 8 lamp cycles, chosen by a 2-bit range select. Shifting the channels in time spreads the supply current over the period and lets the display scan its backlight.

The lamp-cycle tick and the period-start pulse come from outside the block. The shared signal is exported so that other controllers can follow it.

Top module: `burst_stagger_dimmer`

## Requirements
- R1: After reset, `dim_o` and every `burst_o` bit stay low until the first period-start pulse, whatever the lamp ticks do.
- R2: The length L of a period is the number of lamp ticks seen on non-start cycles since the previous start pulse, or since reset. From the cycle after a start pulse, a phase count P counts lamp ticks from zero and saturates at 65535. `dim_o` is high while P < floor(L·D/256), where D is the duty of R3.
- R3: The effective code is `bright_i` with positive slope (`slope_neg_i`=0) and 255−`bright_i` with negative slope. From that effective code b, the duty is D = 26 + floor(230·(b+1)/256), so D runs from 26/256 up to 256/256.
- R4: D = 256 occurs for code FFh with positive slope and 00h with negative slope. It keeps `dim_o` high for the whole period, however long that period turns out to be.
- R5: `dim_disable_i`=1 at a start pulse gives full duty for that period, whatever the brightness code.
- R6: Brightness, slope, disable, range select and stagger codes are sampled only in the start-pulse cycle. Changes to them inside a period have no effect until the next start.
- R7: The step multiplier M is 8, 4, 2 or 1 for `range_sel_i` = 00, 01, 10 or 11. Channel c is delayed by d_c = code_c·M lamp ticks, where code_c is `stagger_i[8c+7:8c]`.
- R8: `burst_o[c]` is high while P ≥ d_c and, unless the duty is full, P < d_c + floor(L·D/256). A burst still high at the next start pulse is cut off there. A code of 00h makes `burst_o[c]` equal to `dim_o`.
- R9: A channel whose delay d_c reaches or passes the number of ticks in the current period produces no burst in that period.
- R10: `dim_o` falls only in the cycle after a lamp tick or a start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lamp_tick_i | input | 1 | One-cycle pulse per lamp cycle |
| period_start_i | input | 1 | One-cycle pulse starting a dimming period |
| bright_i | input | 8 | Brightness code |
| slope_neg_i | input | 1 | 1 selects negative slope |
| range_sel_i | input | 2 | Stagger step multiplier select |
| dim_disable_i | input | 1 | 1 forces full duty |
| stagger_i | input | 32 | Four 8-bit stagger codes, channel 0 in the low byte |
| burst_o | output | 4 | Per-channel burst enable |
| dim_o | output | 1 | Shared dimming signal |

## Verification
The properties assume that period-start and lamp-tick pulses last one cycle. They also assume that any tick arriving in a start cycle is meant to be ignored. Each property is built only on the cycle after a start, or on edges of `dim_o`, so it holds for any brightness and period length. The stimulus never raises a tick together with a start. It covers periods of 0, 3, 300 and 400 ticks, at tick gaps of 1 to 3 cycles. It also changes every sampled input in the middle of a period, so the hold behaviour is exercised.

// File: rtl/burst_dim_pkg.sv
package burst_dim_pkg;
  typedef enum logic [1:0] {
    RNG_X8 = 2'b00,
    RNG_X4 = 2'b01,
    RNG_X2 = 2'b10,
    RNG_X1 = 2'b11
  } range_e;

  function automatic logic [3:0] step_mult(input logic [1:0] sel);
    case (range_e'(sel))
      RNG_X8:  return 4'd8;
      RNG_X4:  return 4'd4;
      RNG_X2:  return 4'd2;
      default: return 4'd1;
    endcase
  endfunction
endpackage

// File: rtl/burst_duty_map.sv
module burst_duty_map #(
  parameter int CODE_W   = 8,
  parameter int DUTY_MIN = 26
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              slope_neg_i,
  input  logic              disable_i,
  output logic [CODE_W:0]   duty_o,
  output logic              full_o
);
  localparam int DUTY_W = CODE_W + 1;
  localparam int SPAN   = (2 ** CODE_W) - DUTY_MIN;
  localparam int PROD_W = 2 * CODE_W + 2;

  logic [CODE_W-1:0] eff;
  logic [PROD_W-1:0] prod;

  assign eff    = slope_neg_i ? ~code_i : code_i;
  assign prod   = PROD_W'(SPAN) * (PROD_W'(eff) + PROD_W'(1));
  assign duty_o = DUTY_W'(DUTY_MIN) + DUTY_W'(prod >> CODE_W);
  assign full_o = disable_i | (duty_o == DUTY_W'(2 ** CODE_W));
endmodule

// File: rtl/burst_period_track.sv
module burst_period_track #(
  parameter int LEN_W  = 16,
  parameter int CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              start_i,
  input  logic [CODE_W:0]   duty_i,
  input  logic              full_i,
  output logic [LEN_W-1:0]  ph_o,
  output logic [LEN_W-1:0]  high_o,
  output logic              full_o,
  output logic              active_o,
  output logic              dim_o
);
  localparam int PROD_W = LEN_W + CODE_W + 1;

  logic [LEN_W-1:0]  ph_q, high_q;
  logic              full_q, active_q;
  logic [PROD_W-1:0] prod;

  // high time scales the length of the period that just ended
  assign prod = PROD_W'(ph_q) * PROD_W'(duty_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q     <= '0;
      high_q   <= '0;
      full_q   <= 1'b0;
      active_q <= 1'b0;
    end else if (start_i) begin
      ph_q     <= '0;
      high_q   <= LEN_W'(prod >> CODE_W);
      full_q   <= full_i;
      active_q <= 1'b1;
    end else if (tick_i && (ph_q != '1)) begin
      ph_q <= ph_q + 1'b1;
    end
  end

  assign ph_o     = ph_q;
  assign high_o   = high_q;
  assign full_o   = full_q;
  assign active_o = active_q;
  assign dim_o    = active_q & (full_q | (ph_q < high_q));
endmodule

// File: rtl/burst_stagger_gate.sv
module burst_stagger_gate
  import burst_dim_pkg::*;
#(
  parameter int N_CH   = 4,
  parameter int CODE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic [1:0]               range_sel_i,
  input  logic [N_CH*CODE_W-1:0]   stagger_i,
  input  logic [LEN_W-1:0]         ph_i,
  input  logic [LEN_W-1:0]         high_i,
  input  logic                     full_i,
  input  logic                     active_i,
  output logic [N_CH-1:0]          burst_o
);
  localparam int DLY_W = CODE_W + 4;
  localparam int CMP_W = ((LEN_W > DLY_W) ? LEN_W : DLY_W) + 1;

  logic [3:0] mult;
  assign mult = step_mult(range_sel_i);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [DLY_W-1:0] dly_q;
    logic [CMP_W-1:0] stop_w;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      dly_q <= '0;
      else if (start_i) dly_q <= DLY_W'(stagger_i[c*CODE_W +: CODE_W]) * DLY_W'(mult);
    end

    assign stop_w     = CMP_W'(dly_q) + CMP_W'(high_i);
    assign burst_o[c] = active_i & (CMP_W'(ph_i) >= CMP_W'(dly_q))
                      & (full_i | (CMP_W'(ph_i) < stop_w));
  end
endmodule

// File: rtl/burst_stagger_dimmer.sv
module burst_stagger_dimmer #(
  parameter int N_CH     = 4,
  parameter int CODE_W   = 8,
  parameter int LEN_W    = 16,
  parameter int DUTY_MIN = 26
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lamp_tick_i,
  input  logic                   period_start_i,
  input  logic [CODE_W-1:0]      bright_i,
  input  logic                   slope_neg_i,
  input  logic [1:0]             range_sel_i,
  input  logic                   dim_disable_i,
  input  logic [N_CH*CODE_W-1:0] stagger_i,
  output logic [N_CH-1:0]        burst_o,
  output logic                   dim_o
);
  logic [CODE_W:0]  duty;
  logic             full_now, full_q, active_q;
  logic [LEN_W-1:0] ph, high;

  burst_duty_map #(.CODE_W(CODE_W), .DUTY_MIN(DUTY_MIN)) u_map (
    .code_i      (bright_i),
    .slope_neg_i (slope_neg_i),
    .disable_i   (dim_disable_i),
    .duty_o      (duty),
    .full_o      (full_now)
  );

  burst_period_track #(.LEN_W(LEN_W), .CODE_W(CODE_W)) u_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (lamp_tick_i),
    .start_i  (period_start_i),
    .duty_i   (duty),
    .full_i   (full_now),
    .ph_o     (ph),
    .high_o   (high),
    .full_o   (full_q),
    .active_o (active_q),
    .dim_o    (dim_o)
  );

  burst_stagger_gate #(.N_CH(N_CH), .CODE_W(CODE_W), .LEN_W(LEN_W)) u_gate (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (period_start_i),
    .range_sel_i (range_sel_i),
    .stagger_i   (stagger_i),
    .ph_i        (ph),
    .high_i      (high),
    .full_i      (full_q),
    .active_i    (active_q),
    .burst_o     (burst_o)
  );
endmodule

// File: rtl/burst_stagger_dimmer_chk.sv
module burst_stagger_dimmer_chk #(
  parameter int N_CH   = 4,
  parameter int CODE_W = 8
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   lamp_tick_i,
  input logic                   period_start_i,
  input logic [CODE_W-1:0]      bright_i,
  input logic                   slope_neg_i,
  input logic                   dim_disable_i,
  input logic [N_CH*CODE_W-1:0] stagger_i,
  input logic [N_CH-1:0]        burst_o,
  input logic                   dim_o
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             seen_q <= 1'b0;
    else if (period_start_i) seen_q <= 1'b1;
  end

  assert_quiet_before_start_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> (burst_o == '0) && !dim_o);

  assert_full_code_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i && (slope_neg_i ? (bright_i == '0) : (&bright_i)) |=> dim_o);

  assert_disable_full_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_start_i && dim_disable_i |=> dim_o);

  assert_dim_fall_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(dim_o) |-> $past(lamp_tick_i) || $past(period_start_i));

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    assert_zero_code_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      period_start_i && (stagger_i[c*CODE_W +: CODE_W] == '0) |=> burst_o[c] == dim_o);
    assert_delayed_start_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      period_start_i && (stagger_i[c*CODE_W +: CODE_W] != '0) |=> !burst_o[c]);
  end
endmodule

bind burst_stagger_dimmer burst_stagger_dimmer_chk #(.N_CH(N_CH), .CODE_W(CODE_W)) chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lamp_tick_i    (lamp_tick_i),
  .period_start_i (period_start_i),
  .bright_i       (bright_i),
  .slope_neg_i    (slope_neg_i),
  .dim_disable_i  (dim_disable_i),
  .stagger_i      (stagger_i),
  .burst_o        (burst_o),
  .dim_o          (dim_o)
);

// File: tb/burst_stagger_dimmer_tb_top.sv
`timescale 1ns/1ps
module burst_stagger_dimmer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, start = 1'b0;
  logic [7:0]  bright = 8'h80;
  logic        slope = 1'b0, dis = 1'b0;
  logic [1:0]  rsel = 2'b10;
  logic [31:0] stag = 32'h714B_2600;
  logic [3:0]  burst;
  logic        dim;

  always #2.5 clk = ~clk;

  burst_stagger_dimmer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .lamp_tick_i(tick), .period_start_i(start),
    .bright_i(bright), .slope_neg_i(slope), .range_sel_i(rsel),
    .dim_disable_i(dis), .stagger_i(stag), .burst_o(burst), .dim_o(dim)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit chk_en = 1'b0;
  string cur_req = "R1";

  // behavioural reference
  int m_ph, m_high, m_act, m_full;
  int m_d[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_high = 0; m_act = 0; m_full = 0;
      foreach (m_d[i]) m_d[i] = 0;
    end else if (start) begin
      int b, duty, mul;
      b    = slope ? 255 - int'(bright) : int'(bright);
      duty = 26 + (230 * (b + 1)) / 256;
      m_full = (dis || duty == 256) ? 1 : 0;
      m_high = (m_ph * duty) / 256;
      mul  = (rsel == 2'b00) ? 8 : (rsel == 2'b01) ? 4 : (rsel == 2'b10) ? 2 : 1;
      foreach (m_d[i]) m_d[i] = int'(stag[8*i +: 8]) * mul;
      m_ph  = 0;
      m_act = 1;
    end else if (tick && m_ph < 65535) begin
      m_ph = m_ph + 1;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      bit e;
      e = (m_act != 0) && (m_full != 0 || m_ph < m_high);
      n_chk++;
      if (dim !== e) begin
        n_fail++;
        $display("FAIL %s dim_o got %0b expected %0b (phase %0d)", cur_req, dim, e, m_ph);
      end
      for (int c = 0; c < 4; c++) begin
        e = (m_act != 0) && (m_ph >= m_d[c]) && (m_full != 0 || m_ph < m_d[c] + m_high);
        n_chk++;
        if (burst[c] !== e) begin
          n_fail++;
          $display("FAIL %s burst_o[%0d] got %0b expected %0b (phase %0d)", cur_req, c, burst[c], e, m_ph);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog %s got hung expected completion", cur_req);
      summary();
      $finish;
    end
  end

  // one start pulse then n ticks, one every gap cycles; mut_at changes all sampled inputs mid-period (R6)
  task automatic run_period(int n, int gap, int mut_at = -1);
    @(negedge clk); start = 1'b1; tick = 1'b0;
    for (int k = 0; k < n; k++) begin
      if (k == mut_at) begin
        bright = ~bright; slope = ~slope; rsel = ~rsel; stag = ~stag; dis = ~dis;
      end
      for (int g = 1; g < gap; g++) begin
        @(negedge clk); start = 1'b0; tick = 1'b0;
      end
      @(negedge clk); start = 1'b0; tick = 1'b1;
    end
    @(negedge clk); start = 1'b0; tick = 1'b0;
  endtask

  initial begin
    chk_en = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1";
    for (int k = 0; k < 20; k++) begin @(negedge clk); tick = (k % 2 == 0); end
    @(negedge clk); tick = 1'b0;

    cur_req = "R2 R8";
    run_period(300, 1); run_period(300, 1); run_period(300, 3);

    cur_req = "R3";
    slope = 1'b1; bright = 8'h20;
    run_period(300, 1); run_period(300, 2);
    slope = 1'b0; bright = 8'h00;
    run_period(300, 1); run_period(300, 1);

    cur_req = "R4";
    bright = 8'hFF;
    run_period(300, 1); run_period(350, 1);
    slope = 1'b1; bright = 8'h00;
    run_period(300, 1);

    cur_req = "R5";
    slope = 1'b0; bright = 8'h10; dis = 1'b1;
    run_period(300, 1); run_period(200, 2);
    dis = 1'b0;

    cur_req = "R7";
    stag = 32'h3020_1001; bright = 8'h90;
    for (int r = 0; r < 4; r++) begin
      rsel = 2'(r);
      run_period(400, 2); run_period(400, 1);
    end

    cur_req = "R9";
    rsel = 2'b00; stag = 32'hFF60_2800; bright = 8'hC0;
    run_period(300, 1); run_period(300, 1); run_period(300, 1);

    cur_req = "R6";
    rsel = 2'b10; stag = 32'h714B_2600; bright = 8'h40; slope = 1'b0; dis = 1'b0;
    run_period(300, 1); run_period(300, 1, 120); run_period(300, 1); run_period(300, 1, 50);
    dis = 1'b0;

    cur_req = "R10";
    bright = 8'h00; slope = 1'b0; stag = 32'h0102_0300; rsel = 2'b11;
    run_period(3, 1); run_period(0, 1); run_period(40, 3); run_period(40, 1);
    repeat (5) @(negedge clk);

    chk_en = 1'b0;
    summary();
    $finish;
  end
endmodule